// File: doc/BRIEF.md
# PLL reprogramming sequencer

This block changes a phase-locked loop's settings in an order that keeps the loop's output safe while its dividers move. A single start strobe carries a request: input divider M, feedback divider N, post-divider exponent P, charge-pump code and VCO gain code. The block then issues four register writes to the loop's control and tuning words, one per cycle:

- program the dividers with the bypass bit set;
- update the tuning word;
- set the enable bit;
- release bypass.

It then waits a programmable number of clock cycles before it reports the new rate as ready.

Every write is read-modify-write. Bits of the control and tuning words that the request does not own keep the value the loop held at the start strobe.

One loop can be marked as the shared peripheral loop. Once that loop carries its override bit it is never reprogrammed. The block only compares the requested settings against the live ones and returns a status code. A mismatch also sets a sticky invalid flag.

The request's rate terms, reference rate times N and the combined divisor M shifted left by P, are exported. This lets the output rate Fo = Fi·N / (M·2^P) be checked elsewhere.

Top module: `pll_seq`

## Requirements
- R1: After reset, busy, ready, status_valid, cfg_invalid, base_we and misc_we are all 0.
- R2: A start accepted with the sequencer idle, and without the check condition of R6, produces exactly four writes in the four cycles that follow the start edge, and no other writes. The order is:
  - base write: M in bits [4:0], N in [14:5], P in [17:15], bypass (bit 31) = 1, enable (bit 30) = 0;
  - misc write;
  - base write equal to the first with enable = 1;
  - base write equal to the third with bypass = 0.
- R3: The misc write puts the charge-pump code in bits [11:8] and the VCO gain code in bits [3:0]. Every other misc bit equals misc_rdata as sampled at the start edge.
- R4: In the base writes, all bits other than M, N, P, enable and bypass equal base_rdata as sampled at the start edge. The exception is the override bit (bit 28), which is forced to 1 when is_periph was high at the start.
- R5: After a programming sequence, ready is high for exactly one cycle: the SETTLE-th cycle after the start edge. In that cycle status_valid is 1 and status is 0 (programmed). busy is high from the cycle after the start edge through the ready cycle, and low in the cycle after it.
- R6: When a start carries is_periph = 1 while base_rdata bit 28 is 1, no write is issued. Instead the block forms a request word: base_rdata with the requested M, N and P placed in their fields and bit 30 forced to 1. In the cycle after the start edge, status_valid is 1. status is 1 (already correct) if the request word equals base_rdata and cfg_invalid was 0; otherwise status is 2 (error). A mismatch sets cfg_invalid.
- R7: cfg_invalid, once set, stays set until reset. While it is set, a matching check of R6 still returns status 2.
- R8: A start that arrives while busy is 1 is ignored. The writes, rate outputs and ready timing all follow the request already in progress.
- R9: From the cycle after an accepted start, fi_n equals ref_rate·N and div_ml equals M·2^P for that request. Both hold until the next accepted start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Start strobe carrying a request |
| is_periph | input | 1 | Request targets the shared peripheral loop |
| ref_rate | input | 32 | Reference rate Fi |
| cfg_m | input | 5 | Input divider M |
| cfg_n | input | 10 | Feedback divider N |
| cfg_p | input | 3 | Post-divider exponent P |
| cfg_cp | input | 4 | Charge-pump code |
| cfg_vg | input | 4 | VCO gain code |
| base_rdata | input | 32 | Current control word of the loop |
| misc_rdata | input | 32 | Current tuning word of the loop |
| base_we | output | 1 | Control word write strobe |
| base_wdata | output | 32 | Control word write data |
| misc_we | output | 1 | Tuning word write strobe |
| misc_wdata | output | 32 | Tuning word write data |
| busy | output | 1 | A request is in progress |
| ready | output | 1 | One-cycle pulse: new rate is settled |
| status_valid | output | 1 | status is valid this cycle |
| status | output | 2 | 0 programmed, 1 already correct, 2 error |
| cfg_invalid | output | 1 | Sticky flag: peripheral loop mismatch seen |
| fi_n | output | 42 | ref_rate times N |
| div_ml | output | 12 | M shifted left by P |

## Verification
The bench builds the sequencer with SETTLE = 9 and keeps the default field widths. With this value the ready pulse lands a few cycles after the last write, so every step can be checked and each run stays short. Because the write steps occupy only the first four cycles, a second start dropped into the middle of a sequence is seen to be ignored. The widths let random requests reach the largest M with P = 7, the widest divisor output. The loop model in the bench keeps whatever was written, so the override set by a peripheral program turns the next peripheral request into a check. That makes the match, mismatch and sticky-error cases reachable in sequence.

// File: rtl/pll_seq_pkg.sv
package pll_seq_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_BASE, ST_MISC, ST_EN, ST_UNBYP, ST_WAIT, ST_DONE
  } seq_state_t;

  localparam logic [1:0] STS_PROGRAMMED = 2'd0;
  localparam logic [1:0] STS_ALREADY    = 2'd1;
  localparam logic [1:0] STS_ERROR      = 2'd2;
endpackage

// File: rtl/pll_seq_words.sv
module pll_seq_words #(
  parameter int WORD_W = 32,
  parameter int MW = 5,
  parameter int NW = 10,
  parameter int PW = 3,
  parameter int CPW = 4,
  parameter int VGW = 4,
  parameter int CP_LSB = 8,
  parameter int VG_LSB = 0
) (
  input  logic [WORD_W-1:0] cur_base,
  input  logic [WORD_W-1:0] cur_misc,
  input  logic [MW-1:0]     m,
  input  logic [NW-1:0]     n,
  input  logic [PW-1:0]     p,
  input  logic [CPW-1:0]    cp,
  input  logic [VGW-1:0]    vg,
  input  logic              force_ovr,
  input  logic [WORD_W-1:0] chk_base,
  input  logic [MW-1:0]     chk_m,
  input  logic [NW-1:0]     chk_n,
  input  logic [PW-1:0]     chk_p,
  output logic [WORD_W-1:0] w_prog,
  output logic [WORD_W-1:0] w_en,
  output logic [WORD_W-1:0] w_run,
  output logic [WORD_W-1:0] w_misc,
  output logic              chk_match
);
  localparam int M_LSB   = 0;
  localparam int N_LSB   = MW;
  localparam int P_LSB   = MW + NW;
  localparam int OVR_BIT = WORD_W - 4;
  localparam int EN_BIT  = WORD_W - 2;
  localparam int BYP_BIT = WORD_W - 1;

  function automatic logic [WORD_W-1:0] put_fields(input logic [WORD_W-1:0] w,
      input logic [MW-1:0] fm, input logic [NW-1:0] fn, input logic [PW-1:0] fp);
    logic [WORD_W-1:0] r;
    r = w;
    r[M_LSB +: MW] = fm;
    r[N_LSB +: NW] = fn;
    r[P_LSB +: PW] = fp;
    return r;
  endfunction

  logic [WORD_W-1:0] chk_req;

  always_comb begin
    w_prog = put_fields(cur_base, m, n, p);
    w_prog[BYP_BIT] = 1'b1;
    w_prog[EN_BIT]  = 1'b0;
    w_prog[OVR_BIT] = cur_base[OVR_BIT] | force_ovr;
    w_en = w_prog;
    w_en[EN_BIT] = 1'b1;
    w_run = w_en;
    w_run[BYP_BIT] = 1'b0;
    w_misc = cur_misc;
    w_misc[CP_LSB +: CPW] = cp;
    w_misc[VG_LSB +: VGW] = vg;
    chk_req = put_fields(chk_base, chk_m, chk_n, chk_p);
    chk_req[EN_BIT] = 1'b1;
    chk_match = (chk_req == chk_base);
  end
endmodule

// File: rtl/pll_seq_rate.sv
module pll_seq_rate #(
  parameter int FIW = 32,
  parameter int MW = 5,
  parameter int NW = 10,
  parameter int PW = 3,
  localparam int FN_W = FIW + NW,
  localparam int DW = MW + (1 << PW) - 1
) (
  input  logic [FIW-1:0]  fi,
  input  logic [MW-1:0]   m,
  input  logic [NW-1:0]   n,
  input  logic [PW-1:0]   p,
  output logic [FN_W-1:0] fi_n,
  output logic [DW-1:0]   div_ml
);
  function automatic logic [FN_W-1:0] rate_num(input logic [FIW-1:0] f, input logic [NW-1:0] k);
    return FN_W'(f) * FN_W'(k);
  endfunction

  function automatic logic [DW-1:0] rate_den(input logic [MW-1:0] d, input logic [PW-1:0] e);
    return DW'(d) << e;
  endfunction

  assign fi_n   = rate_num(fi, n);
  assign div_ml = rate_den(m, p);
endmodule

// File: rtl/pll_seq_fsm.sv
module pll_seq_fsm
  import pll_seq_pkg::*;
#(
  parameter int SETTLE = 16,
  localparam int CNT_W = $clog2(SETTLE + 1)
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic       chk_path,
  input  logic       chk_match,
  output logic       accept,
  output logic       busy,
  output logic       base_we,
  output logic       misc_we,
  output logic [1:0] base_sel,
  output logic       ready,
  output logic       status_valid,
  output logic [1:0] status,
  output logic       cfg_invalid
);
  seq_state_t state_q;
  logic [CNT_W-1:0] cnt_q;
  logic [1:0] chk_sts_q;
  logic inv_q;

  assign busy   = (state_q != ST_IDLE);
  assign accept = start && !busy;
  assign ready  = (state_q == ST_WAIT) && (cnt_q == CNT_W'(SETTLE));
  assign base_we = (state_q == ST_BASE) || (state_q == ST_EN) || (state_q == ST_UNBYP);
  assign misc_we = (state_q == ST_MISC);
  assign base_sel = (state_q == ST_EN) ? 2'd1 : (state_q == ST_UNBYP) ? 2'd2 : 2'd0;
  assign status_valid = ready || (state_q == ST_DONE);
  assign status = (state_q == ST_DONE) ? chk_sts_q : STS_PROGRAMMED;
  assign cfg_invalid = inv_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q <= '0;
      chk_sts_q <= STS_PROGRAMMED;
      inv_q <= 1'b0;
    end else begin
      if (accept) cnt_q <= CNT_W'(1);
      else if (busy && cnt_q != {CNT_W{1'b1}}) cnt_q <= cnt_q + CNT_W'(1);
      unique case (state_q)
        ST_IDLE: if (accept) begin
          if (chk_path) begin
            state_q <= ST_DONE;
            chk_sts_q <= (chk_match && !inv_q) ? STS_ALREADY : STS_ERROR;
            if (!chk_match) inv_q <= 1'b1;
          end else begin
            state_q <= ST_BASE;
          end
        end
        ST_BASE:  state_q <= ST_MISC;
        ST_MISC:  state_q <= ST_EN;
        ST_EN:    state_q <= ST_UNBYP;
        ST_UNBYP: state_q <= ST_WAIT;
        ST_WAIT:  if (ready) state_q <= ST_IDLE;
        default:  state_q <= ST_IDLE;
      endcase
    end
  end

  a_r2_single_write: assert property (@(posedge clk) disable iff (!rst_n)
    !(base_we && misc_we));
  a_r2_misc_follows_base: assert property (@(posedge clk) disable iff (!rst_n)
    misc_we |-> $past(base_we));
  a_r5_ready_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    ready |=> !ready && !busy);
  a_r5_ready_status: assert property (@(posedge clk) disable iff (!rst_n)
    ready |-> status_valid && status == STS_PROGRAMMED && !base_we && !misc_we);
  a_r6_check_no_write: assert property (@(posedge clk) disable iff (!rst_n)
    (status_valid && status != STS_PROGRAMMED) |-> !base_we && !misc_we && !ready);
  a_r7_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_invalid |=> cfg_invalid);
endmodule

// File: rtl/pll_seq.sv
module pll_seq #(
  parameter int WORD_W = 32,
  parameter int FIW = 32,
  parameter int MW = 5,
  parameter int NW = 10,
  parameter int PW = 3,
  parameter int CPW = 4,
  parameter int VGW = 4,
  parameter int CP_LSB = 8,
  parameter int VG_LSB = 0,
  parameter int SETTLE = 16,
  localparam int FN_W = FIW + NW,
  localparam int DW = MW + (1 << PW) - 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              is_periph,
  input  logic [FIW-1:0]    ref_rate,
  input  logic [MW-1:0]     cfg_m,
  input  logic [NW-1:0]     cfg_n,
  input  logic [PW-1:0]     cfg_p,
  input  logic [CPW-1:0]    cfg_cp,
  input  logic [VGW-1:0]    cfg_vg,
  input  logic [WORD_W-1:0] base_rdata,
  input  logic [WORD_W-1:0] misc_rdata,
  output logic              base_we,
  output logic [WORD_W-1:0] base_wdata,
  output logic              misc_we,
  output logic [WORD_W-1:0] misc_wdata,
  output logic              busy,
  output logic              ready,
  output logic              status_valid,
  output logic [1:0]        status,
  output logic              cfg_invalid,
  output logic [FN_W-1:0]   fi_n,
  output logic [DW-1:0]     div_ml
);
  localparam int OVR_BIT = WORD_W - 4;
  localparam int EN_BIT  = WORD_W - 2;
  localparam int BYP_BIT = WORD_W - 1;
  localparam logic [WORD_W-1:0] MISC_OWN =
      (((WORD_W'(1) << CPW) - 1) << CP_LSB) | (((WORD_W'(1) << VGW) - 1) << VG_LSB);

  logic accept, chk_path, chk_match;
  logic [1:0] base_sel;
  logic [MW-1:0] m_q;
  logic [NW-1:0] n_q;
  logic [PW-1:0] p_q;
  logic [CPW-1:0] cp_q;
  logic [VGW-1:0] vg_q;
  logic periph_q;
  logic [FIW-1:0] ref_q;
  logic [WORD_W-1:0] base_cur_q, misc_cur_q;
  logic [WORD_W-1:0] w_prog, w_en, w_run, w_misc;

  assign chk_path = is_periph && base_rdata[OVR_BIT];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_q <= '0; n_q <= '0; p_q <= '0; cp_q <= '0; vg_q <= '0;
      periph_q <= 1'b0; ref_q <= '0; base_cur_q <= '0; misc_cur_q <= '0;
    end else if (accept) begin
      m_q <= cfg_m; n_q <= cfg_n; p_q <= cfg_p; cp_q <= cfg_cp; vg_q <= cfg_vg;
      periph_q <= is_periph; ref_q <= ref_rate;
      base_cur_q <= base_rdata; misc_cur_q <= misc_rdata;
    end
  end

  pll_seq_fsm #(.SETTLE(SETTLE)) u_fsm (
    .clk(clk), .rst_n(rst_n), .start(start), .chk_path(chk_path),
    .chk_match(chk_match), .accept(accept), .busy(busy), .base_we(base_we),
    .misc_we(misc_we), .base_sel(base_sel), .ready(ready),
    .status_valid(status_valid), .status(status), .cfg_invalid(cfg_invalid)
  );

  pll_seq_words #(.WORD_W(WORD_W), .MW(MW), .NW(NW), .PW(PW), .CPW(CPW),
                  .VGW(VGW), .CP_LSB(CP_LSB), .VG_LSB(VG_LSB)) u_words (
    .cur_base(base_cur_q), .cur_misc(misc_cur_q), .m(m_q), .n(n_q), .p(p_q),
    .cp(cp_q), .vg(vg_q), .force_ovr(periph_q), .chk_base(base_rdata),
    .chk_m(cfg_m), .chk_n(cfg_n), .chk_p(cfg_p), .w_prog(w_prog), .w_en(w_en),
    .w_run(w_run), .w_misc(w_misc), .chk_match(chk_match)
  );

  pll_seq_rate #(.FIW(FIW), .MW(MW), .NW(NW), .PW(PW)) u_rate (
    .fi(ref_q), .m(m_q), .n(n_q), .p(p_q), .fi_n(fi_n), .div_ml(div_ml)
  );

  assign base_wdata = (base_sel == 2'd1) ? w_en : (base_sel == 2'd2) ? w_run : w_prog;
  assign misc_wdata = w_misc;

  a_r2_unbypass_enabled: assert property (@(posedge clk) disable iff (!rst_n)
    (base_we && !base_wdata[BYP_BIT]) |-> base_wdata[EN_BIT]);
  a_r2_first_bypassed: assert property (@(posedge clk) disable iff (!rst_n)
    misc_we |-> $past(base_wdata[BYP_BIT] && !base_wdata[EN_BIT]));
  a_r3_misc_preserve: assert property (@(posedge clk) disable iff (!rst_n)
    misc_we |-> ((misc_wdata ^ misc_cur_q) & ~MISC_OWN) == '0);
  a_r4_ovr_forced: assert property (@(posedge clk) disable iff (!rst_n)
    (base_we && periph_q) |-> base_wdata[OVR_BIT]);
  a_r8_hold_request: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start) |=> $stable(fi_n) && $stable(div_ml));
endmodule

// File: tb/pll_seq_bench.sv
module pll_seq_bench;
  localparam int CLK_P = 10;
  localparam int SET = 9;
  localparam logic [31:0] FMASK = 32'h0003_FFFF;
  localparam logic [31:0] OVR = 32'h1000_0000;
  localparam logic [31:0] EN  = 32'h4000_0000;
  localparam logic [31:0] BYP = 32'h8000_0000;

  logic clk = 1'b0, rst_n = 1'b0;
  logic start = 1'b0, is_periph = 1'b0;
  logic [31:0] ref_rate = '0;
  logic [4:0] cfg_m = '0;
  logic [9:0] cfg_n = '0;
  logic [2:0] cfg_p = '0;
  logic [3:0] cfg_cp = '0, cfg_vg = '0;
  logic [31:0] base_q = '0, misc_q = '0;
  logic base_we, misc_we, busy, ready, status_valid, cfg_invalid;
  logic [31:0] base_wdata, misc_wdata;
  logic [1:0] status;
  logic [41:0] fi_n;
  logic [11:0] div_ml;
  int n_chk = 0, n_bad = 0;
  logic exp_inv = 1'b0;

  always #(CLK_P/2) clk = ~clk;

  pll_seq #(.SETTLE(SET)) u_pll_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .is_periph(is_periph),
    .ref_rate(ref_rate), .cfg_m(cfg_m), .cfg_n(cfg_n), .cfg_p(cfg_p),
    .cfg_cp(cfg_cp), .cfg_vg(cfg_vg), .base_rdata(base_q), .misc_rdata(misc_q),
    .base_we(base_we), .base_wdata(base_wdata), .misc_we(misc_we),
    .misc_wdata(misc_wdata), .busy(busy), .ready(ready),
    .status_valid(status_valid), .status(status), .cfg_invalid(cfg_invalid),
    .fi_n(fi_n), .div_ml(div_ml)
  );

  // passive loop model: keeps what is written
  always @(posedge clk) begin
    if (base_we) base_q <= base_wdata;
    if (misc_we) misc_q <= misc_wdata;
  end

  task automatic check(input logic ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [31:0] exp_first(input logic [31:0] b, input logic [4:0] m,
      input logic [9:0] n, input logic [2:0] p, input logic per);
    logic [31:0] f;
    f = {14'd0, p, n, m};
    return (b & ~FMASK & ~EN) | f | BYP | (per ? OVR : 32'd0);
  endfunction

  function automatic logic [31:0] exp_misc(input logic [31:0] w, input logic [3:0] cp, input logic [3:0] vg);
    return (w & 32'hFFFF_F0F0) | ({28'd0, cp} << 8) | {28'd0, vg};
  endfunction

  task automatic run_prog(input logic [4:0] m, input logic [9:0] n, input logic [2:0] p,
      input logic [3:0] cp, input logic [3:0] vg, input logic per,
      input logic [31:0] b0, input logic [31:0] mi0, input logic [31:0] fr, input logic overlap);
    logic [31:0] e1, em;
    logic [41:0] efn;
    logic [11:0] edv;
    e1 = exp_first(b0, m, n, p, per);
    em = exp_misc(mi0, cp, vg);
    efn = 42'(fr) * 42'(n);
    edv = 12'(m) * (12'd1 << p);
    @(negedge clk);
    base_q = b0; misc_q = mi0;
    cfg_m = m; cfg_n = n; cfg_p = p; cfg_cp = cp; cfg_vg = vg;
    is_periph = per; ref_rate = fr; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check(base_we && !misc_we && base_wdata == e1, "R2/R4 step1 base", {31'd0, base_we, base_wdata}, {32'd1, e1});
    check(fi_n == efn, "R9 fi_n", 64'(fi_n), 64'(efn));
    check(div_ml == edv, "R9 div_ml", 64'(div_ml), 64'(edv));
    check(busy, "R5 busy", 64'(busy), 64'd1);
    if (overlap) begin
      cfg_m = ~m; cfg_n = ~n; cfg_p = ~p; cfg_cp = ~cp; cfg_vg = ~vg;
      ref_rate = ~fr; is_periph = ~per; start = 1'b1;
    end
    @(negedge clk);
    start = 1'b0;
    check(misc_we && !base_we && misc_wdata == em, "R3 misc write", {31'd0, misc_we, misc_wdata}, {32'd1, em});
    @(negedge clk);
    check(base_we && base_wdata == (e1 | EN), "R2 enable write", {31'd0, base_we, base_wdata}, {32'd1, e1 | EN});
    @(negedge clk);
    check(base_we && base_wdata == ((e1 | EN) & ~BYP), "R2 unbypass write", {31'd0, base_we, base_wdata}, {32'd1, (e1 | EN) & ~BYP});
    if (overlap) begin
      check(fi_n == efn && div_ml == edv, "R8 request held", 64'(fi_n), 64'(efn));
    end
    for (int i = 5; i <= SET; i++) begin
      @(negedge clk);
      check(ready == (i == SET) && !base_we && !misc_we, "R5 ready timing", {62'd0, ready, base_we}, {63'd0, i == SET});
      if (i == SET) begin
        check(status_valid && status == 2'd0, "R5 status programmed", {61'd0, status_valid, status}, 64'h4);
      end
    end
    @(negedge clk);
    check(!busy && !ready && !base_we && !misc_we, "R5 idle after ready", {62'd0, busy, ready}, 64'd0);
  endtask

  task automatic run_chk(input logic [4:0] m, input logic [9:0] n, input logic [2:0] p, input logic [31:0] b0);
    logic match;
    logic [1:0] es;
    match = ((b0 & FMASK) == {14'd0, p, n, m}) && b0[30];
    es = (match && !exp_inv) ? 2'd1 : 2'd2;
    if (!match) exp_inv = 1'b1;
    @(negedge clk);
    base_q = b0;
    cfg_m = m; cfg_n = n; cfg_p = p; is_periph = 1'b1; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check(status_valid && status == es && !base_we && !misc_we, "R6 check status",
          {60'd0, status_valid, base_we, status}, {61'd4, es});
    check(cfg_invalid == exp_inv, "R7 sticky flag", 64'(cfg_invalid), 64'(exp_inv));
    @(negedge clk);
    check(!busy && !status_valid && !base_we && !misc_we && base_q == b0, "R6 no reprogram",
          {30'd0, busy, status_valid, base_q}, {32'd0, b0});
  endtask

  task automatic finish_up;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    #(CLK_P * 150000);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired actual=hung expected=done");
    finish_up();
  end

  initial begin
    logic [31:0] b;
    void'($urandom(32'd24681));
    repeat (3) @(negedge clk);
    check(!busy && !ready && !status_valid && !cfg_invalid && !base_we && !misc_we,
          "R1 reset state", {58'd0, busy, ready, status_valid, cfg_invalid, base_we, misc_we}, 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check(!busy && !base_we && !misc_we, "R1 idle after reset", {62'd0, busy, base_we}, 64'd0);
    // non-peripheral with override bit already set: programs, keeps override
    run_prog(5'd12, 10'd408, 3'd0, 4'd8, 4'd3, 1'b0, 32'h1234_5678 | OVR, 32'hA5A5_5A5A, 32'd12000000, 1'b0);
    // peripheral program from clean state sets override
    run_prog(5'd13, 10'd408, 3'd1, 4'd8, 4'd1, 1'b1, 32'h0000_0000, 32'h0004_0000, 32'd13000000, 1'b0);
    // now loop holds override; matching check
    b = base_q;
    run_chk(5'd13, 10'd408, 3'd1, b);
    // mismatch -> error, flag set
    run_chk(5'd13, 10'd407, 3'd1, b);
    // match again -> still error while flag is set
    run_chk(5'd13, 10'd408, 3'd1, b);
    // non-peripheral program still works, flag stays
    run_prog(5'd31, 10'd1023, 3'd7, 4'd15, 4'd15, 1'b0, 32'hFFFF_FFFF & ~OVR, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 1'b0);
    check(cfg_invalid, "R7 flag stays", 64'(cfg_invalid), 64'd1);
    // second start while busy is ignored
    run_prog(5'd1, 10'd100, 3'd2, 4'd4, 4'd2, 1'b0, 32'h0F00_0000, 32'h0000_3000, 32'd26000000, 1'b1);
    // random programming runs
    for (int k = 0; k < 40; k++) begin
      run_prog(5'($urandom_range(1, 31)), 10'($urandom), 3'($urandom), 4'($urandom), 4'($urandom),
               1'($urandom), $urandom & ~OVR, $urandom, $urandom, 1'($urandom_range(0, 3) == 0));
    end
    // random checks against an overridden loop
    for (int k = 0; k < 20; k++) begin
      b = ($urandom | OVR);
      if (k % 2 == 0) run_chk(b[4:0], b[14:5], b[17:15], b | EN);
      else run_chk(5'($urandom), 10'($urandom), 3'($urandom), b);
    end
    finish_up();
  end
endmodule